// File: doc/BRIEF.md
# USB Endpoint Control Register File

This block holds the per-endpoint control and status words of a full-speed USB device controller, together with an interrupt status word and a device address word. Software reaches all of them through a simple register bus. A transfer engine, outside this block, reports finished transactions through an event port. Each event names one endpoint and says whether a transmit finished, a receive finished, or a receive carried a SETUP token. The engine also reports bus reset, suspend and wakeup.

Every endpoint word mixes three kinds of write behaviour in one 16-bit register:
- Handshake status fields and data-toggle bits flip where software writes a one.
- Completion flags are cleared only where software writes a zero.
- Configuration fields are plain read/write.

Because of these rules, software can change one field with a single write, without a read-modify-write race against the hardware. The interrupt status word summarises which endpoint has work pending. It gives the lowest-numbered endpoint first.

Register select map: selects 0 to NUM_EP-1 address the endpoint words, select NUM_EP addresses interrupt status, and select NUM_EP+1 addresses the device address. Reads are combinational. Writes take effect at the rising clock edge.

Top module: `usb_ep_regfile`

## Requirements
- R1: After reset, every endpoint word, the interrupt status word and the device address word read as zero.
- R2: Endpoint word bits 13:12 (receive status) and 9:8 (transmit status) invert wherever a written bit is one and hold wherever it is zero. Status codes are 00 disabled, 01 stall, 10 NAK and 11 valid.
- R3: Endpoint word bit 14 (receive data toggle) and bit 10 (transmit data toggle) invert when written with one and hold when written with zero.
- R4: Endpoint word bit 15 (receive complete) and bit 11 (transmit complete) are cleared by writing zero and are left unchanged by writing one.
- R5: Endpoint word bits 6:0 are plain read/write configuration: bits 6:5 type, bit 4 kind, bits 3:0 endpoint number.
- R6: Endpoint word bit 7 is read-only. A receive completion loads it with the event's SETUP indication, and no write changes it.
- R7: A transmit completion event sets bit 11 and inverts bit 10. It changes the transmit status from valid to NAK and leaves any other status code unchanged. The receive fields are not affected.
- R8: A receive completion event acts the same way on bits 15, 14 and 13:12, and leaves the transmit fields untouched.
- R9: Interrupt status bit 15 is high while any endpoint has a completion flag set. Bits IDX_W-1:0 then name the lowest such endpoint. Both fields are read-only.
- R10: Interrupt status bits 14 (bus reset), 13 (suspend) and 12 (wakeup) are set by their events and cleared by writing zero. Writing one leaves them unchanged. An event in the same cycle as a clearing write wins.
- R11: The device address word holds a 7-bit address in bits 6:0 and an enable bit in bit 7. Bits 15:8 read as zero.
- R12: A bus reset event clears every endpoint word and the device address word to zero, and sets the bus reset flag.
- R13: When a software write and a completion event hit the same endpoint in the same cycle, the event's setting of the completion flag wins over a clearing write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | SEL_W | Register select |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| ev_ep | input | IDX_W | Endpoint named by a completion event |
| ev_tx_done | input | 1 | Transmit completed on ev_ep |
| ev_rx_done | input | 1 | Receive completed on ev_ep |
| ev_rx_setup | input | 1 | The completed receive was a SETUP packet |
| ev_bus_reset | input | 1 | USB bus reset seen |
| ev_suspend | input | 1 | Bus suspend seen |
| ev_wakeup | input | 1 | Bus wakeup seen |

## Verification
The hardest case to reach is a software write and a completion event that land on the same endpoint in the same clock cycle. The write clears the completion flag while the event sets it. The bench drives the write strobe and the event strobe at the same falling edge, so both reach the register at one rising edge. It then checks that the flag survives and that the status and toggle still follow the event. The same alignment is used on the interrupt status word for the wakeup flag. The flip fields are swept exhaustively: every start code is combined with every write pattern on every endpoint.

// File: rtl/usb_epr_pkg.sv
package usb_epr_pkg;

    localparam int REG_W = 16;

    // interrupt status bit positions
    localparam int ISR_XFER_BIT = 15;
    localparam int ISR_RST_BIT  = 14;
    localparam int ISR_SUSP_BIT = 13;
    localparam int ISR_WAKE_BIT = 12;

    typedef enum logic [1:0] {
        ST_DISABLED = 2'b00,
        ST_STALL    = 2'b01,
        ST_NAK      = 2'b10,
        ST_VALID    = 2'b11
    } ep_stat_e;

    // MSB first: bit 15 down to bit 0
    typedef struct packed {
        logic       rx_done;
        logic       rx_tog;
        ep_stat_e   rx_stat;
        logic       tx_done;
        logic       tx_tog;
        ep_stat_e   tx_stat;
        logic       setup;
        logic [1:0] ep_type;
        logic       ep_kind;
        logic [3:0] ep_num;
    } ep_reg_t;

endpackage

// File: rtl/ep_reg.sv
module ep_reg
    import usb_epr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr,
    input  logic    wen,
    input  ep_reg_t wdata,
    input  logic    tx_ev,
    input  logic    rx_ev,
    input  logic    rx_setup,
    output ep_reg_t q
);

    ep_reg_t r, nxt;

    always_comb begin
        nxt = r;
        if (wen) begin
            nxt.ep_num  = wdata.ep_num;
            nxt.ep_kind = wdata.ep_kind;
            nxt.ep_type = wdata.ep_type;
            nxt.tx_stat = ep_stat_e'(r.tx_stat ^ wdata.tx_stat);
            nxt.rx_stat = ep_stat_e'(r.rx_stat ^ wdata.rx_stat);
            nxt.tx_tog  = r.tx_tog ^ wdata.tx_tog;
            nxt.rx_tog  = r.rx_tog ^ wdata.rx_tog;
            nxt.tx_done = r.tx_done & wdata.tx_done;
            nxt.rx_done = r.rx_done & wdata.rx_done;
        end
        if (tx_ev) begin
            nxt.tx_done = 1'b1;
            nxt.tx_tog  = ~nxt.tx_tog;
            if (r.tx_stat == ST_VALID)
                nxt.tx_stat = ST_NAK;
        end
        if (rx_ev) begin
            nxt.rx_done = 1'b1;
            nxt.rx_tog  = ~nxt.rx_tog;
            nxt.setup   = rx_setup;
            if (r.rx_stat == ST_VALID)
                nxt.rx_stat = ST_NAK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r <= '0;
        else if (clr)
            r <= '0;
        else
            r <= nxt;
    end

    assign q = r;

    // R7
    tx_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ev && !clr) |=> q.tx_done);

    // R7
    tx_valid_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ev && !clr && q.tx_stat == ST_VALID) |=> (q.tx_stat == ST_NAK));

    // R8
    rx_valid_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ev && !clr && q.rx_stat == ST_VALID) |=> (q.rx_stat == ST_NAK));

    // R6
    setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ev && !clr) |=> $stable(q.setup));

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wen && !clr) |=> ($stable(q.ep_num) && $stable(q.ep_kind) && $stable(q.ep_type)));

    // R4
    done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.tx_done && !clr && !(wen && !wdata.tx_done)) |=> q.tx_done);

endmodule

// File: rtl/ep_scan.sv
module ep_scan #(
    parameter int NUM_EP = 8,
    parameter int IDX_W  = 3
) (
    input  logic [NUM_EP-1:0] pend,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);

    always_comb begin
        any = |pend;
        idx = '0;
        for (int i = NUM_EP - 1; i >= 0; i--) begin
            if (pend[i])
                idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/usb_ep_regfile.sv
module usb_ep_regfile
    import usb_epr_pkg::*;
#(
    parameter int NUM_EP = 8,
    localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int SEL_W = $clog2(NUM_EP + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             reg_wen,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic [IDX_W-1:0] ev_ep,
    input  logic             ev_tx_done,
    input  logic             ev_rx_done,
    input  logic             ev_rx_setup,
    input  logic             ev_bus_reset,
    input  logic             ev_suspend,
    input  logic             ev_wakeup
);

    localparam logic [SEL_W-1:0] ISR_SEL   = SEL_W'(NUM_EP);
    localparam logic [SEL_W-1:0] DADDR_SEL = SEL_W'(NUM_EP + 1);

    ep_reg_t           ep_q [NUM_EP];
    logic [NUM_EP-1:0] ep_pend;
    logic              scan_any;
    logic [IDX_W-1:0]  scan_idx;
    logic              rst_flag, susp_flag, wake_flag;
    logic [7:0]        dev_addr;
    logic              isr_wen, daddr_wen;

    assign isr_wen   = reg_wen && (reg_sel == ISR_SEL);
    assign daddr_wen = reg_wen && (reg_sel == DADDR_SEL);

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        logic sel_hit;
        logic ev_hit;
        assign sel_hit = reg_wen && (reg_sel == SEL_W'(g));
        assign ev_hit  = (ev_ep == IDX_W'(g));

        ep_reg u_ep (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (ev_bus_reset),
            .wen      (sel_hit),
            .wdata    (ep_reg_t'(reg_wdata)),
            .tx_ev    (ev_tx_done && ev_hit),
            .rx_ev    (ev_rx_done && ev_hit),
            .rx_setup (ev_rx_setup),
            .q        (ep_q[g])
        );

        assign ep_pend[g] = ep_q[g].tx_done | ep_q[g].rx_done;
    end

    ep_scan #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_scan (
        .pend (ep_pend),
        .any  (scan_any),
        .idx  (scan_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_flag  <= 1'b0;
            susp_flag <= 1'b0;
            wake_flag <= 1'b0;
        end else begin
            rst_flag  <= ev_bus_reset | (rst_flag  & ~(isr_wen & ~reg_wdata[ISR_RST_BIT]));
            susp_flag <= ev_suspend   | (susp_flag & ~(isr_wen & ~reg_wdata[ISR_SUSP_BIT]));
            wake_flag <= ev_wakeup    | (wake_flag & ~(isr_wen & ~reg_wdata[ISR_WAKE_BIT]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dev_addr <= '0;
        else if (ev_bus_reset)
            dev_addr <= '0;
        else if (daddr_wen)
            dev_addr <= reg_wdata[7:0];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel < SEL_W'(NUM_EP)) begin
            reg_rdata = ep_q[reg_sel[IDX_W-1:0]];
        end else if (reg_sel == ISR_SEL) begin
            reg_rdata[ISR_XFER_BIT] = scan_any;
            reg_rdata[ISR_RST_BIT]  = rst_flag;
            reg_rdata[ISR_SUSP_BIT] = susp_flag;
            reg_rdata[ISR_WAKE_BIT] = wake_flag;
            reg_rdata[IDX_W-1:0]    = scan_idx;
        end else if (reg_sel == DADDR_SEL) begin
            reg_rdata[7:0] = dev_addr;
        end
    end

    logic lower_pend;
    always_comb begin
        lower_pend = 1'b0;
        for (int i = 0; i < NUM_EP; i++)
            if (ep_pend[i] && (IDX_W'(i) < scan_idx))
                lower_pend = 1'b1;
    end

    // R9
    xfer_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_any |-> ep_pend[scan_idx]);

    // R9
    lowest_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_any |-> !lower_pend);

    // R12
    bus_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bus_reset |=> (dev_addr == 8'h00 && ep_pend == '0 && rst_flag));

    // R10
    susp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_suspend |=> susp_flag);

endmodule

// File: tb/usb_ep_regfile_tb.sv
module usb_ep_regfile_tb;

    localparam int NUM_EP = 8;
    localparam int IDX_W  = 3;
    localparam int SEL_W  = 4;
    localparam logic [SEL_W-1:0] ISR   = 4'd8;
    localparam logic [SEL_W-1:0] DADDR = 4'd9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SEL_W-1:0] reg_sel = '0;
    logic reg_wen = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [IDX_W-1:0] ev_ep = '0;
    logic ev_tx_done = 0, ev_rx_done = 0, ev_rx_setup = 0;
    logic ev_bus_reset = 0, ev_suspend = 0, ev_wakeup = 0;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    usb_ep_regfile #(.NUM_EP(NUM_EP)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_ep(ev_ep),
        .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done), .ev_rx_setup(ev_rx_setup),
        .ev_bus_reset(ev_bus_reset), .ev_suspend(ev_suspend), .ev_wakeup(ev_wakeup)
    );

    function automatic logic [15:0] word(input logic rxd, input logic rxt, input logic [1:0] rxs,
                                         input logic txd, input logic txt, input logic [1:0] txs,
                                         input logic [6:0] cfg);
        return {rxd, rxt, rxs, txd, txt, txs, 1'b0, cfg};
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [SEL_W-1:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [SEL_W-1:0] s, output logic [15:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic ev(input int ep, input logic tx, input logic rx, input logic su,
                      input logic br, input logic sp, input logic wk);
        @(negedge clk);
        ev_ep = IDX_W'(ep); ev_tx_done = tx; ev_rx_done = rx; ev_rx_setup = su;
        ev_bus_reset = br; ev_suspend = sp; ev_wakeup = wk;
        @(negedge clk);
        ev_tx_done = 0; ev_rx_done = 0; ev_rx_setup = 0;
        ev_bus_reset = 0; ev_suspend = 0; ev_wakeup = 0;
    endtask

    // drive fields to target values using flip writes, keeping done flags
    task automatic set_ep(input int ep, input logic [1:0] rxs, input logic rxt,
                          input logic [1:0] txs, input logic txt, input logic [6:0] cfg);
        logic [15:0] cur;
        rd(SEL_W'(ep), cur);
        wr(SEL_W'(ep), word(1'b1, cur[14] ^ rxt, cur[13:12] ^ rxs,
                            1'b1, cur[10] ^ txt, cur[9:8] ^ txs, cfg));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v, cur, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < NUM_EP + 2; s++) begin
            rd(SEL_W'(s), v);
            check("R1 reset", v, 16'h0000);
        end

        // R2 / R3: exhaustive flip sweep over every field, start and pattern
        for (int ep = 0; ep < NUM_EP; ep++) begin
            for (int f = 0; f < 4; f++) begin
                int pos;
                int msk;
                pos = (f == 0) ? 8 : (f == 1) ? 12 : (f == 2) ? 10 : 14;
                msk = (f < 2) ? 3 : 1;
                for (int tgt = 0; tgt <= msk; tgt++) begin
                    for (int pat = 0; pat <= msk; pat++) begin
                        rd(SEL_W'(ep), cur);
                        wr(SEL_W'(ep), 16'h8800 | 16'((((cur >> pos) & msk) ^ tgt) << pos) | (cur & 16'h007F));
                        rd(SEL_W'(ep), cur);
                        wr(SEL_W'(ep), 16'h8800 | 16'(pat << pos) | (cur & 16'h007F));
                        rd(SEL_W'(ep), v);
                        exp = (cur & ~16'(msk << pos)) | 16'((tgt ^ pat) << pos);
                        check((f < 2) ? "R2 status flip" : "R3 toggle flip", v, exp);
                    end
                end
            end
        end

        // R5: configuration fields, full sweep on endpoint 2 and one per endpoint
        for (int c = 0; c < 128; c++) begin
            wr(4'd2, 16'h8800 | 16'(c));
            rd(4'd2, v);
            check("R5 cfg rw", v & 16'h007F, 16'(c));
        end
        for (int ep = 0; ep < NUM_EP; ep++) begin
            wr(SEL_W'(ep), 16'h8800 | 16'((ep * 13 + 5) & 7'h7F));
            rd(SEL_W'(ep), v);
            check("R5 cfg per ep", v & 16'h007F, 16'((ep * 13 + 5) & 7'h7F));
        end

        // R7: transmit completion from valid
        set_ep(3, 2'b01, 1'b0, 2'b11, 1'b0, 7'h25);
        ev(3, 1, 0, 0, 0, 0, 0);
        rd(4'd3, v);
        check("R7 tx from valid", v, word(0, 0, 2'b01, 1, 1, 2'b10, 7'h25));
        // R7: transmit completion from stall keeps stall
        set_ep(3, 2'b01, 1'b0, 2'b01, 1'b1, 7'h25);
        ev(3, 1, 0, 0, 0, 0, 0);
        rd(4'd3, v);
        check("R7 tx from stall", v, word(0, 0, 2'b01, 1, 0, 2'b01, 7'h25));

        // R8 / R6: receive completion carrying SETUP
        set_ep(5, 2'b11, 1'b1, 2'b00, 1'b0, 7'h11);
        ev(5, 0, 1, 1, 0, 0, 0);
        rd(4'd5, v);
        check("R8 rx from valid", v, word(1, 0, 2'b10, 0, 0, 2'b00, 7'h11) | 16'h0080);
        // R6: write cannot clear setup bit
        wr(4'd5, word(1, 0, 0, 1, 0, 0, 7'h11));
        rd(4'd5, v);
        check("R6 setup read-only", v, word(1, 0, 2'b10, 0, 0, 2'b00, 7'h11) | 16'h0080);

        // R9: two endpoints pending, lowest reported
        rd(ISR, v);
        check("R9 lowest id", v, 16'h8003);
        // R4: clear tx done on ep3 by writing zero
        wr(4'd3, word(1, 0, 0, 0, 0, 0, 7'h25));
        rd(4'd3, v);
        check("R4 clear by zero", v, word(0, 0, 2'b01, 0, 0, 2'b01, 7'h25));
        rd(ISR, v);
        check("R9 next id", v, 16'h8005);
        // R4: writing one keeps rx done on ep5
        wr(4'd5, word(1, 0, 0, 1, 0, 0, 7'h11));
        rd(4'd5, v);
        check("R4 one keeps", v[15], 1'b1);
        wr(4'd5, word(0, 0, 0, 1, 0, 0, 7'h11));
        rd(ISR, v);
        check("R9 none pending", v, 16'h0000);

        // R8 / R6: a plain receive clears setup, leaves tx fields
        set_ep(5, 2'b11, 1'b0, 2'b10, 1'b1, 7'h11);
        ev(5, 0, 1, 0, 0, 0, 0);
        rd(4'd5, v);
        check("R8 rx plain", v, word(1, 1, 2'b10, 0, 1, 2'b10, 7'h11));
        // R6: writing a one to the setup bit has no effect
        wr(4'd5, word(0, 0, 0, 1, 0, 0, 7'h11) | 16'h0080);
        rd(4'd5, v);
        check("R6 setup no set", v, word(0, 1, 2'b10, 0, 1, 2'b10, 7'h11));

        // R9: pend descending, each new one becomes the lowest
        for (int i = NUM_EP - 1; i >= 0; i--) begin
            ev(i, 1, 0, 0, 0, 0, 0);
            rd(ISR, v);
            check("R9 sweep set", v, 16'h8000 | 16'(i));
        end
        for (int i = 0; i < NUM_EP; i++) begin
            rd(SEL_W'(i), cur);
            wr(SEL_W'(i), 16'h8000 | (cur & 16'h007F));
            rd(ISR, v);
            check("R9 sweep clear", v, (i < NUM_EP - 1) ? (16'h8000 | 16'(i + 1)) : 16'h0000);
        end

        // R10: suspend and wakeup flags
        ev(0, 0, 0, 0, 0, 1, 0);
        ev(0, 0, 0, 0, 0, 0, 1);
        rd(ISR, v);
        check("R10 flags set", v, 16'h3000);
        wr(ISR, 16'hFFFF);
        rd(ISR, v);
        check("R10 write one keeps", v, 16'h3000);
        wr(ISR, 16'hDFFF);
        rd(ISR, v);
        check("R10 clear suspend", v, 16'h1000);
        // R10: wakeup event wins over same-cycle clear
        @(negedge clk);
        reg_sel = ISR; reg_wdata = 16'h0000; reg_wen = 1'b1; ev_wakeup = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0; ev_wakeup = 1'b0;
        rd(ISR, v);
        check("R10 event wins", v, 16'h1000);

        // R13: same-cycle clearing write and transmit completion on ep1
        set_ep(1, 2'b00, 1'b0, 2'b11, 1'b0, 7'h3C);
        rd(4'd1, cur);
        @(negedge clk);
        reg_sel = 4'd1; reg_wdata = word(1, 0, 0, 0, 0, 0, 7'h3C); reg_wen = 1'b1;
        ev_ep = 3'd1; ev_tx_done = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0; ev_tx_done = 1'b0;
        rd(4'd1, v);
        exp = cur;
        exp[11] = 1'b1;
        exp[10] = ~cur[10];
        exp[9:8] = (cur[9:8] == 2'b11) ? 2'b10 : cur[9:8];
        check("R13 event wins", v, exp);

        // R11: device address
        wr(DADDR, 16'h0085);
        rd(DADDR, v);
        check("R11 addr+enable", v, 16'h0085);
        wr(DADDR, 16'hFF7A);
        rd(DADDR, v);
        check("R11 upper ignored", v, 16'h007A);

        // R12: bus reset
        ev(0, 0, 0, 0, 1, 0, 0);
        for (int ep = 0; ep < NUM_EP; ep++) begin
            rd(SEL_W'(ep), v);
            check("R12 ep cleared", v, 16'h0000);
        end
        rd(DADDR, v);
        check("R12 addr cleared", v, 16'h0000);
        rd(ISR, v);
        check("R12 reset flag", v, 16'h5000);
        wr(ISR, 16'h0000);
        rd(ISR, v);
        check("R10 clear all", v, 16'h0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule